// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm Compare

This block is a slow time base for a system clock domain. A 20-bit down-counting divider turns the input clock into a one-cycle tick. Each tick advances a free-running 32-bit count. Three things raise flags: every tick, the count reaching a programmed alarm value, and the count wrapping from all ones to zero. Each flag has its own interrupt enable, and each flag drives its own interrupt line.

Software reaches the block through a small register port with a single-cycle write and a combinational read. After reset the divider reload is 32767, so a 32.768 kHz clock gives one tick per second. A control bit places a fixed divide-by-128 stage in front of the divider. This stage serves the case where the block is clocked from a fast clock.

Top module: `rtc_tick_alarm`

## Requirements
- R1: After reset:
  - reload reads 32767.
  - count reads 0.
  - alarm reads 32'hFFFF_FFFF.
  - flags and control read 0.
  - all three interrupt lines are low.
- R2: With reload value N, a tick occurs once every N+1 divider steps, and each tick adds exactly 1 to the count. In normal mode there is one step per clock. The count changes only by a tick or by a write.
- R3: A write to the count (address 1) or to the reload (address 0) restarts the division phase.
  - After the write, N+1 clocks pass before the next increment. N is the reload in force after the write.
  - The written count value reads back at once.
  - No tick happens on the edge where the write takes place.
- R4: The second flag (flags bit 0) sets on every tick.
- R5: The alarm flag (flags bit 1) sets on a tick whose new count equals the alarm register (address 2). It stays clear for any other count value.
- R6: The overflow flag (flags bit 2) sets on the tick that wraps the count from 32'hFFFF_FFFF to 0.
- R7: The flags at address 3 are sticky.
  - Writing 1 to a bit clears that bit.
  - Writing 0 to a bit has no effect on it.
  - If a flag is set and cleared in the same cycle, the set wins.
- R8: Control bits 0, 1 and 2 (address 4) enable the second, alarm and overflow interrupts. Each interrupt line is high exactly while its flag and its enable are both 1.
- R9: When control bit 3 is 1, the divider steps only once per 128 clocks. With reload 1, the first increment after a count write comes 256 clocks after the write.
- R10: Addresses 0 to 4 read back the reload (20 bits, zero-extended), count, alarm, flags and control registers. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| irq_second | output | 1 | Tick interrupt |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_overflow | output | 1 | Wrap interrupt |

## Verification
The properties assume at most one register write per cycle. They also assume that a count write and a tick never coincide, because the write suppresses the tick.

The stimulus:
- issues writes one at a time, each lasting one clock;
- changes the reload only through the port;
- leaves the alarm at all ones except in the alarm test.

As a result, every increment the checker sees comes from a genuine tick.

// File: rtl/rtc_tick_alarm.sv
module rtc_tick_alarm #(
  parameter int CW         = 32,
  parameter int PW         = 20,
  parameter int PDW        = 7,
  parameter int RST_RELOAD = 32767
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          irq_second,
  output logic          irq_alarm,
  output logic          irq_overflow
);
  localparam logic [2:0] A_REL = 3'd0, A_CNT = 3'd1, A_ALM = 3'd2, A_FLG = 3'd3, A_CTL = 3'd4;

  logic [PW-1:0]  reload_q, psc_q;
  logic [PDW-1:0] pre_q;
  logic [CW-1:0]  cnt_q, alm_q, cnt_inc;
  logic [2:0]     flg_q, flg_set, flg_clr;
  logic [3:0]     ctl_q;
  logic           wr_rel, wr_cnt, step, tick;

  assign wr_rel  = wr_en && wr_addr == A_REL;
  assign wr_cnt  = wr_en && wr_addr == A_CNT;
  assign step    = ctl_q[3] ? &pre_q : 1'b1;
  assign tick    = step && psc_q == '0 && !wr_rel && !wr_cnt;
  assign cnt_inc = cnt_q + 1'b1;
  assign flg_set = {tick && &cnt_q, tick && cnt_inc == alm_q, tick};
  assign flg_clr = (wr_en && wr_addr == A_FLG) ? wr_data[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= PW'(RST_RELOAD);
      psc_q    <= PW'(RST_RELOAD);
      pre_q    <= '0;
    end else begin
      if (wr_rel) reload_q <= wr_data[PW-1:0];
      if (wr_rel)                  psc_q <= wr_data[PW-1:0];
      else if (wr_cnt)             psc_q <= reload_q;
      else if (step && psc_q == 0) psc_q <= reload_q;
      else if (step)               psc_q <= psc_q - 1'b1;
      if (wr_rel || wr_cnt || !ctl_q[3]) pre_q <= '0;
      else                               pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      alm_q <= '1;
      flg_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_cnt)     cnt_q <= wr_data;
      else if (tick)  cnt_q <= cnt_inc;
      if (wr_en && wr_addr == A_ALM) alm_q <= wr_data;
      if (wr_en && wr_addr == A_CTL) ctl_q <= wr_data[3:0];
      flg_q <= (flg_q & ~flg_clr) | flg_set;
    end
  end

  always_comb begin
    case (rd_addr)
      A_REL:   rd_data = CW'(reload_q);
      A_CNT:   rd_data = cnt_q;
      A_ALM:   rd_data = alm_q;
      A_FLG:   rd_data = CW'(flg_q);
      A_CTL:   rd_data = CW'(ctl_q);
      default: rd_data = '0;
    endcase
  end

  assign irq_second   = flg_q[0] & ctl_q[0];
  assign irq_alarm    = flg_q[1] & ctl_q[1];
  assign irq_overflow = flg_q[2] & ctl_q[2];
endmodule

// File: rtl/rtc_tick_alarm_chk.sv
module rtc_tick_alarm_chk #(
  parameter int CW = 32,
  parameter int PW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] alm,
  input logic [PW-1:0] psc,
  input logic [PW-1:0] reload,
  input logic [2:0]    flg
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 3'd1) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  p_divider_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    psc <= reload);

  p_alarm_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[1]) |-> cnt == $past(alm));

  p_wrap_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[2]) |-> ($past(cnt) == '1 && cnt == '0));

  p_sticky_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[0] && !(wr_en && wr_addr == 3'd3 && wr_data[0])) |=> flg[0]);
endmodule

bind rtc_tick_alarm rtc_tick_alarm_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt(cnt_q), .alm(alm_q), .psc(psc_q), .reload(reload_q), .flg(flg_q)
);

// File: tb/test_rtc_tick_alarm.sv
module test_rtc_tick_alarm;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data, v;
  logic        irq_second, irq_alarm, irq_overflow;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_tick_alarm i_rtc_tick_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_second(irq_second),
    .irq_alarm(irq_alarm), .irq_overflow(irq_overflow)
  );

  localparam int NV = 4;
  localparam logic [31:0] V_REL  [NV] = '{32'd3, 32'd0, 32'd7, 32'd1};
  localparam logic [31:0] V_LOAD [NV] = '{32'd100, 32'd5, 32'hFFFF_FFF0, 32'd0};
  localparam int          V_WAIT [NV] = '{40, 17, 64, 9};
  localparam logic [31:0] V_EXP  [NV] = '{32'd110, 32'd22, 32'hFFFF_FFF8, 32'd4};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #0.5 d = rd_data;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] c;
    #12 rst_n = 1;
    #1;
    rd(3'd0, v); chk("R1 reload", v, 32'd32767);
    rd(3'd1, v); chk("R1 count", v, 0);
    rd(3'd2, v); chk("R1 alarm", v, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R1 flags", v, 0);
    rd(3'd4, v); chk("R1 ctl", v, 0);
    rd(3'd6, v); chk("R10 unmapped", v, 0);
    chk("R1 irqs", {29'd0, irq_second, irq_alarm, irq_overflow}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(3'd0, V_REL[i]);
      wr(3'd1, V_LOAD[i]);
      rd(3'd1, v); chk("R3 load readback", v, V_LOAD[i]);
      edges(V_WAIT[i]);
      rd(3'd1, v); chk("R2 tick period", v, V_EXP[i]);
      rd(3'd0, v); chk("R10 reload readback", v, V_REL[i]);
    end

    wr(3'd3, 32'd7);
    wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFFE);
    edges(1);
    rd(3'd3, v); chk("R5 alarm at default compare", v & 32'd6, 32'd2);
    edges(1);
    rd(3'd1, v); chk("R6 wrap count", v, 0);
    rd(3'd3, v); chk("R6 R4 wrap flags", v, 32'd7);
    wr(3'd4, 32'd7);
    chk("R8 irqs on", {29'd0, irq_second, irq_alarm, irq_overflow}, 32'd7);
    wr(3'd0, 32'd1000);
    wr(3'd3, 32'd0);
    rd(3'd3, v); chk("R7 zero write no effect", v, 32'd7);
    wr(3'd3, 32'd4);
    rd(3'd3, v); chk("R7 clear overflow only", v, 32'd3);
    chk("R8 overflow irq low", {31'd0, irq_overflow}, 0);
    wr(3'd3, 32'd3);
    rd(3'd3, v); chk("R7 clear rest", v, 0);
    chk("R8 irqs off", {29'd0, irq_second, irq_alarm, irq_overflow}, 0);

    wr(3'd0, 32'd1);
    wr(3'd2, 32'd10);
    wr(3'd1, 32'd8);
    edges(3);
    rd(3'd1, v); chk("R5 before match count", v, 32'd9);
    rd(3'd3, v); chk("R5 no alarm off-match", v & 32'd2, 0);
    chk("R8 second irq", {31'd0, irq_second}, 1);
    edges(1);
    rd(3'd1, v); chk("R5 match count", v, 32'd10);
    rd(3'd3, v); chk("R5 alarm flag", v & 32'd2, 32'd2);
    chk("R8 alarm irq", {31'd0, irq_alarm}, 1);

    wr(3'd0, 32'd5);
    edges(3);
    wr(3'd0, 32'd5);
    rd(3'd1, c);
    edges(5);
    rd(3'd1, v); chk("R3 restart no early tick", v, c);
    edges(1);
    rd(3'd1, v); chk("R3 restart tick", v, c + 1);

    wr(3'd4, 32'd15);
    wr(3'd0, 32'd1);
    wr(3'd1, 32'd0);
    edges(255);
    rd(3'd1, v); chk("R9 div128 before", v, 0);
    edges(1);
    rd(3'd1, v); chk("R9 div128 tick", v, 1);
    rd(3'd4, v); chk("R10 ctl readback", v, 32'd15);

    done = 1;
    finish_run();
  end
endmodule